// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Software Clear

This block is a watchdog counter for a small microcontroller. It advances on a one-cycle enable tick taken from one of three clock sources: a low-speed crystal, the system clock divided by four, or a low-speed internal RC oscillator. When the count reaches a power-of-two period chosen by a 3-bit field, the block raises a timeout. What the timeout requests depends on whether the device is asleep. A timeout while the device runs requests a full device reset. A timeout during sleep requests a wake-up together with a reset of only the program counter and stack pointer. In both cases a sticky status flag is set. The CPU core performs the actions, and this block only raises the requests.

Software keeps the watchdog from expiring by clearing it. A configuration input chooses between two clear modes. In single mode one strobe clears the counter. In paired mode two different strobes, first and second, must both arrive, in either order, before the counter is cleared. Repeating the same strobe before its partner arrives does nothing. A halt strobe or a low level on the external reset input always clears the counter and discards any half-finished pairing. The period field sits in a small read/write register.

Top module: `wdog_top`

## Requirements
- R1: `src_sel` picks the counting tick: 0 = crystal tick, 1 = system/4 tick, 2 = RC tick, 3 = no source (the counter holds). Ticks on unselected lines never advance the count.
- R2: While `sleep` is high, system/4 ticks are ignored. Crystal and RC ticks keep counting during sleep.
- R3: With period field value F, the N-th accepted tick after a clear, where N = 2^(8+F), causes a one-cycle timeout pulse on the next clock edge. The count then restarts from zero, so the next timeout again needs N ticks.
- R4: The register reads as 8 bits. Bits 2:0 hold the period field, which is read/write and resets to 3'b111. Bits 7:3 always read as zero, whatever is written to them.
- R5: A timeout taken while `sleep` is low pulses `reset_req` for one cycle and sets `to_flag`. `wake_req` and `ptr_rst_req` stay low.
- R6: A timeout taken while `sleep` is high pulses `wake_req` and `ptr_rst_req` for one cycle and sets `to_flag`. `reset_req` stays low.
- R7: `halt` high, or `ext_rst_n` low, clears the count in that cycle. A clear takes priority over a tick in the same cycle.
- R8: When `pair_mode` = 0 (single mode), `clr_single` clears the count, and `clr_one` and `clr_two` have no effect.
- R9: When `pair_mode` = 1 (paired mode), the count is cleared only once `clr_one` and `clr_two` have both arrived, in either order or in the same cycle. A repeated strobe of the same kind has no effect, and `clr_single` is ignored.
- R10: Any clear of the count (an accepted software clear, `halt`, or `ext_rst_n` low) discards a pending half of a pair. A later lone partner strobe therefore does not clear the count.
- R11: `to_flag` rises on the same edge as the timeout pulse. It stays set through watchdog clears and is cleared only by `rst` or by `flag_clr`. A timeout in the same cycle as `flag_clr` leaves the flag set.
- R12: A period-field write takes effect at the next accepted tick. If the count already meets or exceeds the new limit, that tick produces the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| src_sel | input | 2 | Tick source select (configuration) |
| pair_mode | input | 1 | 0 = single-strobe clear, 1 = paired clear (configuration) |
| tick_xtal | input | 1 | Crystal-derived count enable |
| tick_sys4 | input | 1 | System/4 count enable |
| tick_rc | input | 1 | Internal RC count enable |
| sleep | input | 1 | Device is in idle/sleep |
| clr_single | input | 1 | Single-mode clear strobe |
| clr_one | input | 1 | First paired clear strobe |
| clr_two | input | 1 | Second paired clear strobe |
| halt | input | 1 | Halt strobe, clears the count |
| ext_rst_n | input | 1 | External reset, active low, clears the count |
| flag_clr | input | 1 | Software clear of the timeout status flag |
| reg_we | input | 1 | Period register write enable |
| reg_wdata | input | 8 | Period register write data |
| reg_rdata | output | 8 | Period register read value |
| reset_req | output | 1 | One-cycle full device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| ptr_rst_req | output | 1 | One-cycle program counter / stack pointer reset request |
| to_flag | output | 1 | Sticky timeout status flag |

## Verification
The counter is not visible at the ports, so the hardest case is telling whether a strobe actually cleared it. The bench solves this by ticking once per cycle for a known number of cycles, issuing the strobe, and then counting the ticks to the next timeout: 256 means the count was cleared, 156 means the strobe was ignored. The pairing state is also hidden. The bench reaches it by leaving one half of a pair pending on purpose, clearing the count by halt or external reset, and then checking that the lone partner strobe does not shorten the next timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_SYS4 = 2'd1,
        SRC_RC   = 2'd2,
        SRC_NONE = 2'd3
    } wd_src_e;

    typedef enum logic {
        CLR_SINGLE = 1'b0,
        CLR_PAIRED = 1'b1
    } wd_clr_mode_e;

    typedef struct packed {
        logic fire;
        logic asleep;
    } wd_event_t;

    // A source whose tick is derived from the stopped instruction clock
    function automatic logic halts_in_sleep(input int idx);
        return idx == int'(SRC_SYS4);
    endfunction

endpackage

// File: rtl/wdog_tick_mux.sv
module wdog_tick_mux
    import wdog_pkg::*;
(
    input  logic [NSRC-1:0] ticks,
    input  wd_src_e         src_sel,
    input  logic            sleep,
    output logic            tick_ok
);

    logic [NSRC-1:0] live;
    logic [3:0]      live_ext;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            if (halts_in_sleep(i)) begin : g_gated
                assign live[i] = ticks[i] & ~sleep;
            end else begin : g_free
                assign live[i] = ticks[i];
            end
        end
    endgenerate

    assign live_ext = {{(4-NSRC){1'b0}}, live};

    always_comb begin
        tick_ok = live_ext[src_sel];
    end

endmodule

// File: rtl/wdog_clr_seq.sv
module wdog_clr_seq
    import wdog_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  wd_clr_mode_e mode,
    input  logic         clr_single,
    input  logic         clr_one,
    input  logic         clr_two,
    input  logic         halt,
    input  logic         ext_rst_n,
    output logic         clear
);

    logic half_one_q;
    logic half_two_q;
    logic sw_accept;

    always_comb begin
        if (mode == CLR_SINGLE) begin
            sw_accept = clr_single;
        end else begin
            sw_accept = (clr_one && (half_two_q || clr_two)) ||
                        (clr_two && half_one_q);
        end
        clear = sw_accept || halt || !ext_rst_n;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            half_one_q <= 1'b0;
            half_two_q <= 1'b0;
        end else if (mode == CLR_PAIRED) begin
            if (clr_one) half_one_q <= 1'b1;
            if (clr_two) half_two_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int MIN_EXP = 8,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic             sleep,
    input  logic [SEL_W-1:0] sel,
    output logic             hit,
    output wd_event_t        evt
);

    localparam int CNT_W = MIN_EXP + (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;

    always_comb begin
        span = (CNT_W+1)'(1) << (MIN_EXP + int'(sel));
        last = CNT_W'(span - 1'b1);
        hit  = tick && !clear && (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            evt.fire   <= 1'b0;
            evt.asleep <= 1'b0;
        end else begin
            evt.fire   <= hit;
            evt.asleep <= hit && sleep;
            if (clear || hit) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int MIN_EXP = 8,
    parameter int SEL_W   = 3,
    parameter int REG_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel,
    input  logic             pair_mode,
    input  logic             tick_xtal,
    input  logic             tick_sys4,
    input  logic             tick_rc,
    input  logic             sleep,
    input  logic             clr_single,
    input  logic             clr_one,
    input  logic             clr_two,
    input  logic             halt,
    input  logic             ext_rst_n,
    input  logic             flag_clr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             reset_req,
    output logic             wake_req,
    output logic             ptr_rst_req,
    output logic             to_flag
);

    localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((1 << SEL_W) - 1);

    logic [REG_W-1:0] period_q;
    logic             tick_ok;
    logic             clear;
    logic             hit;
    wd_event_t        evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= IMPL_MASK;
        end else if (reg_we) begin
            period_q <= reg_wdata & IMPL_MASK;
        end
    end

    assign reg_rdata = period_q;

    wdog_tick_mux u_mux (
        .ticks   ({tick_rc, tick_sys4, tick_xtal}),
        .src_sel (wd_src_e'(src_sel)),
        .sleep   (sleep),
        .tick_ok (tick_ok)
    );

    wdog_clr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (wd_clr_mode_e'(pair_mode)),
        .clr_single (clr_single),
        .clr_one    (clr_one),
        .clr_two    (clr_two),
        .halt       (halt),
        .ext_rst_n  (ext_rst_n),
        .clear      (clear)
    );

    wdog_counter #(
        .MIN_EXP (MIN_EXP),
        .SEL_W   (SEL_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_ok),
        .clear (clear),
        .sleep (sleep),
        .sel   (period_q[SEL_W-1:0]),
        .hit   (hit),
        .evt   (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            to_flag <= 1'b0;
        end else if (hit) begin
            to_flag <= 1'b1;
        end else if (flag_clr) begin
            to_flag <= 1'b0;
        end
    end

    assign reset_req   = evt.fire && !evt.asleep;
    assign wake_req    = evt.fire &&  evt.asleep;
    assign ptr_rst_req = evt.asleep;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int SEL_W = 3,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep,
    input logic             halt,
    input logic             ext_rst_n,
    input logic             flag_clr,
    input logic [REG_W-1:0] reg_rdata,
    input logic             reset_req,
    input logic             wake_req,
    input logic             ptr_rst_req,
    input logic             to_flag
);

    // R4
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata >> SEL_W) == '0);

    // R5
    reset_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (to_flag && !wake_req && !$past(sleep)));

    // R6
    wake_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (to_flag && $past(sleep)));

    // R6
    ptr_rst_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_rst_req |-> $past(sleep));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (reset_req || wake_req) |=> !(reset_req || wake_req));

    // R7
    halt_blocks_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        $past(halt) |-> !(reset_req || wake_req));

    // R7
    ext_blocks_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ext_rst_n) |-> !(reset_req || wake_req));

    // R11
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag) |-> (reset_req || wake_req));

    // R11
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(to_flag) |-> $past(flag_clr));

endmodule

bind wdog_top wdog_chk #(.SEL_W(SEL_W), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep       (sleep),
    .halt        (halt),
    .ext_rst_n   (ext_rst_n),
    .flag_clr    (flag_clr),
    .reg_rdata   (reg_rdata),
    .reset_req   (reset_req),
    .wake_req    (wake_req),
    .ptr_rst_req (ptr_rst_req),
    .to_flag     (to_flag)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd0;
    logic       pair_mode = 1'b0;
    logic       tick_xtal = 1'b0, tick_sys4 = 1'b0, tick_rc = 1'b0;
    logic       sleep = 1'b0;
    logic       clr_single = 1'b0, clr_one = 1'b0, clr_two = 1'b0;
    logic       halt = 1'b0, ext_rst_n = 1'b1, flag_clr = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       reset_req, wake_req, ptr_rst_req, to_flag;

    int nvec = 0;
    int nbad = 0;
    int tline = 0;
    int m_n;
    bit m_rst, m_wake, m_ptr;

    always #4 clk = ~clk;

    wdog_top u_dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .pair_mode(pair_mode),
        .tick_xtal(tick_xtal), .tick_sys4(tick_sys4), .tick_rc(tick_rc),
        .sleep(sleep), .clr_single(clr_single), .clr_one(clr_one),
        .clr_two(clr_two), .halt(halt), .ext_rst_n(ext_rst_n),
        .flag_clr(flag_clr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reset_req(reset_req), .wake_req(wake_req),
        .ptr_rst_req(ptr_rst_req), .to_flag(to_flag)
    );

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_tick(bit v);
        tick_xtal = v && (tline == 0);
        tick_sys4 = v && (tline == 1);
        tick_rc   = v && (tline == 2);
    endtask

    task automatic advance(int n);
        set_tick(1'b1);
        repeat (n) cyc();
        set_tick(1'b0);
    endtask

    task automatic measure(int limit);
        m_n = -1; m_rst = 0; m_wake = 0; m_ptr = 0;
        set_tick(1'b1);
        for (int i = 1; i <= limit; i++) begin
            cyc();
            if (reset_req || wake_req) begin
                m_n = i; m_rst = reset_req; m_wake = wake_req; m_ptr = ptr_rst_req;
                break;
            end
        end
        set_tick(1'b0);
    endtask

    // 0 single, 1 first, 2 second, 3 halt, 4 ext reset, 5 flag clear
    task automatic strobe(int which);
        clr_single = (which == 0);
        clr_one    = (which == 1);
        clr_two    = (which == 2);
        halt       = (which == 3);
        ext_rst_n  = (which != 4);
        flag_clr   = (which == 5);
        cyc();
        clr_single = 0; clr_one = 0; clr_two = 0;
        halt = 0; ext_rst_n = 1; flag_clr = 0;
    endtask

    task automatic wr(logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R4 reset value", int'(reg_rdata), 7);
        chk("R11 flag after reset", int'(to_flag), 0);
        chk("R5 no request after reset", int'(reset_req | wake_req), 0);
    endtask

    task automatic t_register();
        wr(8'hFF);
        chk("R4 upper bits read zero", int'(reg_rdata), 7);
        wr(8'hF2);
        chk("R4 field write", int'(reg_rdata), 2);
        wr(8'h00);
        chk("R4 field zero", int'(reg_rdata), 0);
    endtask

    task automatic t_period();
        src_sel = 2'd0; tline = 0;
        measure(40000);
        chk("R3 period 2^8", m_n, 256);
        chk("R5 reset_req on awake timeout", int'(m_rst), 1);
        chk("R5 no wake on awake timeout", int'(m_wake | m_ptr), 0);
        chk("R11 flag set", int'(to_flag), 1);
        measure(40000);
        chk("R3 restart from zero", m_n, 256);
        wr(8'h01);
        measure(40000);
        chk("R3 period 2^9", m_n, 512);
        wr(8'h00);
    endtask

    task automatic t_flag();
        strobe(0);
        chk("R11 flag survives watchdog clear", int'(to_flag), 1);
        strobe(5);
        chk("R11 flag_clr clears flag", int'(to_flag), 0);
    endtask

    task automatic t_source();
        src_sel = 2'd0; tline = 2;
        advance(300);
        tline = 0;
        measure(40000);
        chk("R1 RC tick ignored on crystal select", m_n, 256);
        src_sel = 2'd3;
        for (int k = 0; k < 3; k++) begin
            tline = k;
            advance(100);
        end
        src_sel = 2'd2; tline = 2;
        measure(40000);
        chk("R1 no source holds count", m_n, 256);
        src_sel = 2'd1; tline = 1;
        measure(40000);
        chk("R1 system/4 source counts", m_n, 256);
    endtask

    task automatic t_sleep();
        src_sel = 2'd1; tline = 1; sleep = 1'b1;
        advance(300);
        sleep = 1'b0;
        measure(40000);
        chk("R2 system/4 frozen in sleep", m_n, 256);
        strobe(5);
        src_sel = 2'd2; tline = 2; sleep = 1'b1;
        measure(40000);
        chk("R2 RC counts in sleep", m_n, 256);
        chk("R6 wake_req in sleep", int'(m_wake), 1);
        chk("R6 ptr_rst_req in sleep", int'(m_ptr), 1);
        chk("R6 no reset_req in sleep", int'(m_rst), 0);
        chk("R6 flag set in sleep", int'(to_flag), 1);
        sleep = 1'b0;
        src_sel = 2'd0; tline = 0;
    endtask

    task automatic t_single();
        pair_mode = 1'b0;
        advance(100); strobe(0);
        measure(40000);
        chk("R8 single clear accepted", m_n, 256);
        advance(100); strobe(1); strobe(2);
        measure(40000);
        chk("R8 paired strobes ignored in single mode", m_n, 156);
        advance(100); strobe(3);
        measure(40000);
        chk("R7 halt clears", m_n, 256);
        advance(100); strobe(4);
        measure(40000);
        chk("R7 external reset clears", m_n, 256);
    endtask

    task automatic t_paired();
        pair_mode = 1'b1;
        advance(100); strobe(0);
        measure(40000);
        chk("R9 single strobe ignored in paired mode", m_n, 156);
        advance(100); strobe(1); advance(50); strobe(2);
        measure(40000);
        chk("R9 first then second clears", m_n, 256);
        advance(100); strobe(2); strobe(1);
        measure(40000);
        chk("R9 second then first clears", m_n, 256);
        advance(100); strobe(2); strobe(2);
        measure(40000);
        chk("R9 repeated second has no effect", m_n, 156);
        strobe(3);
        advance(100); strobe(1);
        measure(40000);
        chk("R10 halt discards pending second", m_n, 156);
        strobe(4);
        advance(100); strobe(2);
        measure(40000);
        chk("R10 external reset discards pending first", m_n, 156);
        pair_mode = 1'b0;
    endtask

    task automatic t_write_effect();
        wr(8'h07);
        advance(300);
        wr(8'h00);
        measure(40000);
        chk("R12 shorter period fires on next tick", m_n, 1);
        flag_clr = 1'b1;
        measure(40000);
        flag_clr = 1'b0;
        chk("R11 timeout beats flag_clr", int'(to_flag), 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL all: watchdog got 150000 cycles expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_register();
        t_period();
        t_flag();
        t_source();
        t_sleep();
        t_single();
        t_paired();
        t_write_effect();
        finish_run();
    end

endmodule